// File: doc/BRIEF.md
# DVFS Operating Point Controller

This block is a hardware governor and transition sequencer for dynamic voltage and frequency scaling. It keeps a small table of operating points, each a fixed pair of a supply-voltage code and a clock-frequency code. It chooses a target point from one of three policies: lock low, lock high, or follow the utilization samples. It then steps the voltage regulator and the clock synthesizer to that point in a safe order and waits for each of them to report ready.

A thermal alarm overrides the policy by capping the target below the point in use when the alarm arrived. A sensor wake event sends the utilization-following level to the top of the table. An idle-length prediction either clock-gates the core or, when the predicted idle time is long enough to repay a transition, drops the level to the lowest point. A stuck handshake raises a sticky error. The analog regulator and the synthesizer exist here only as their ready inputs.

The sequencer has nine named states. `SQ_IDLE` is the resting state. `SQ_FDN_SET`, `SQ_FDN_WAIT`, `SQ_VDN_SET` and `SQ_VDN_WAIT` make up a down-scaling sequence. `SQ_VUP_SET`, `SQ_VUP_WAIT`, `SQ_FUP_SET` and `SQ_FUP_WAIT` make up an up-scaling sequence. Each `_SET` state drives one new code for one cycle, and the next state is always the matching `_WAIT` state.
- A `_WAIT` state advances when its ready input is high.
- `SQ_FDN_WAIT` goes to `SQ_VDN_SET`.
- `SQ_VUP_WAIT` goes to `SQ_FUP_SET`.
- `SQ_VDN_WAIT` and `SQ_FUP_WAIT` return to `SQ_IDLE` and commit the new index.
- `SQ_IDLE` goes to `SQ_FDN_SET` when the target is below the current point, and to `SQ_VUP_SET` when it is above.
- Reset enters `SQ_VUP_SET` with target 0.

Top module: `dvfs_opp_ctrl`

## Requirements
- R1: There are NUM_OPP points (default 3), and index 0 is the lowest. Point i uses voltage code V_BASE+i*V_STEP (default 20+8i) and frequency code F_BASE+i*F_STEP (default 16+24i). Whenever busy is low, the code outputs equal the codes of opp_idx, and opp_idx stays below NUM_OPP.
- R2: After reset, opp_idx is 0, the codes are those of point 0, gate_en is 0 and hs_error is 0. busy stays high until one boot sequence completes: a regulator-ready wait followed by a clock-ready wait.
- R3: The policy input is decoded as follows: 1 locks the target to index 0, 2 locks it to the top index, and 0 or 3 follows the utilization level.
- R4: A util_valid sample strictly above cfg_hi_thr raises the utilization level by one, saturating at the top index.
- R5: The utilization level drops by one only after LOW_RUN consecutive valid samples (default 3) strictly below cfg_lo_thr. Any valid sample that is not below cfg_lo_thr restarts the count.
- R6: A down-scaling sequence changes f_code first and v_code after that. An up-scaling sequence changes v_code first and f_code after that. The two codes never change on the same clock edge.
- R7: After each code change, the sequencer waits until the matching ready input (vreg_ready for v_code, clk_ready for f_code) is sampled high, counting from the second cycle after the change. busy is high for the whole sequence, and opp_idx takes the new value only at completion.
- R8: A target change that arrives during a sequence does not abort it. The sequence reaches its own target first, and the new target is served afterwards.
- R9: A rising edge of thermal_alarm captures a cap one below the current opp_idx (or 0 at the lowest point). While the alarm stays high, the target is the lower of the cap and the policy target, under any policy. The hold requested by clock gating does not block this change.
- R10: idle_valid with idle_pred below cfg_breakeven sets the gate. gate_en is high whenever the gate is set and busy is low, and the operating point stays fixed. idle_valid with idle_pred at or above cfg_breakeven clears the gate and sets the utilization level to 0.
- R11: wake_evt sets the utilization level to the top index and clears the gate.
- R12: hs_error is set when a wait state sees its ready input low for cfg_tmo_limit consecutive cycles. Only reset clears it, and the sequence keeps waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| util_valid | input | 1 | Utilization sample strobe |
| util_sample | input | 8 | Utilization sample |
| cfg_hi_thr | input | 8 | Step-up threshold |
| cfg_lo_thr | input | 8 | Step-down threshold |
| policy | input | 2 | Policy select: 0/3 follow load, 1 lowest, 2 highest |
| thermal_alarm | input | 1 | Overheat alarm, level |
| wake_evt | input | 1 | Sensor wake pulse |
| idle_valid | input | 1 | Idle prediction strobe |
| idle_pred | input | 16 | Predicted idle length in cycles |
| cfg_breakeven | input | 16 | Idle length that repays a transition |
| cfg_tmo_limit | input | 16 | Handshake timeout in cycles |
| vreg_ready | input | 1 | Regulator reports stable voltage |
| clk_ready | input | 1 | Clock synthesizer reports lock |
| v_code | output | 6 | Voltage code to the regulator |
| f_code | output | 7 | Frequency code to the synthesizer |
| gate_en | output | 1 | Clock-gate enable |
| busy | output | 1 | Sequence in progress |
| opp_idx | output | 2 | Committed operating point |
| hs_error | output | 1 | Sticky handshake timeout |

## Verification
The hardest situation to reach is a target that changes while a sequence is half done. To get there, the bench switches the policy from lock-low to lock-high on the first cycle in which busy is seen high, and the scoreboard then expects two completions in order: the abandoned-looking target first, then the new one. A related hard case is a step-down request that is held back by clock gating. The bench produces it by sending a short idle prediction and then enough low samples to lower the level, and it checks that busy and the point do not move. The timeout case is forced by a regulator model that holds ready low until the bench releases it.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;

    typedef enum logic [1:0] {
        POL_ONDEMAND    = 2'd0,
        POL_POWERSAVE   = 2'd1,
        POL_PERFORMANCE = 2'd2,
        POL_RSVD        = 2'd3
    } policy_e;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_FDN_SET,
        SQ_FDN_WAIT,
        SQ_VDN_SET,
        SQ_VDN_WAIT,
        SQ_VUP_SET,
        SQ_VUP_WAIT,
        SQ_FUP_SET,
        SQ_FUP_WAIT
    } seq_state_e;

endpackage

// File: rtl/dvfs_governor.sv
module dvfs_governor
    import dvfs_pkg::*;
#(
    parameter int NUM_OPP = 3,
    parameter int UTIL_W  = 8,
    parameter int IDLE_W  = 16,
    parameter int LOW_RUN = 3,
    parameter int IW      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              util_valid,
    input  logic [UTIL_W-1:0] util_sample,
    input  logic [UTIL_W-1:0] cfg_hi_thr,
    input  logic [UTIL_W-1:0] cfg_lo_thr,
    input  policy_e           policy,
    input  logic              thermal_alarm,
    input  logic              wake_evt,
    input  logic              idle_valid,
    input  logic [IDLE_W-1:0] idle_pred,
    input  logic [IDLE_W-1:0] cfg_breakeven,
    input  logic [IW-1:0]     cur_idx,
    output logic [IW-1:0]     tgt_idx,
    output logic              gate_q
);

    localparam int LRW = $clog2(LOW_RUN + 1);
    localparam logic [IW-1:0]  TOP_IDX  = IW'(NUM_OPP - 1);
    localparam logic [LRW-1:0] RUN_LAST = LRW'(LOW_RUN - 1);

    logic [IW-1:0]  od_level;
    logic [LRW-1:0] low_run;
    logic           therm_q;
    logic [IW-1:0]  cap_q;
    logic [IW-1:0]  cap_now;
    logic [IW-1:0]  pol_tgt;
    logic           idle_short;
    logic           util_hi;
    logic           util_lo;

    assign idle_short = idle_pred < cfg_breakeven;
    assign util_hi    = util_sample > cfg_hi_thr;
    assign util_lo    = util_sample < cfg_lo_thr;

    // utilization-following level with hysteresis on the way down
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            od_level <= '0;
            low_run  <= '0;
        end else if (wake_evt) begin
            od_level <= TOP_IDX;
        end else if (idle_valid && !idle_short) begin
            od_level <= '0;
        end else if (util_valid) begin
            if (util_hi) begin
                low_run <= '0;
                if (od_level != TOP_IDX) od_level <= od_level + 1'b1;
            end else if (util_lo) begin
                if (low_run == RUN_LAST) begin
                    low_run <= '0;
                    if (od_level != '0) od_level <= od_level - 1'b1;
                end else begin
                    low_run <= low_run + 1'b1;
                end
            end else begin
                low_run <= '0;
            end
        end
    end

    // clock-gate decision from the idle prediction
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
        end else if (wake_evt) begin
            gate_q <= 1'b0;
        end else if (idle_valid) begin
            gate_q <= idle_short;
        end
    end

    // thermal cap captured on the alarm's rising edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            therm_q <= 1'b0;
            cap_q   <= '0;
        end else begin
            therm_q <= thermal_alarm;
            if (thermal_alarm && !therm_q) cap_q <= cap_now;
        end
    end

    always_comb begin
        if (therm_q)            cap_now = cap_q;
        else if (cur_idx == '0) cap_now = '0;
        else                    cap_now = cur_idx - 1'b1;
    end

    always_comb begin
        unique case (policy)
            POL_POWERSAVE:   pol_tgt = '0;
            POL_PERFORMANCE: pol_tgt = TOP_IDX;
            default:         pol_tgt = od_level;
        endcase
    end

    assign tgt_idx = (thermal_alarm && (cap_now < pol_tgt)) ? cap_now : pol_tgt;

endmodule

// File: rtl/dvfs_sequencer.sv
module dvfs_sequencer
    import dvfs_pkg::*;
#(
    parameter int NUM_OPP = 3,
    parameter int IW      = 2,
    parameter int VW      = 6,
    parameter int FW      = 7,
    parameter int V_BASE  = 20,
    parameter int V_STEP  = 8,
    parameter int F_BASE  = 16,
    parameter int F_STEP  = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] tgt_idx,
    input  logic          hold,
    input  logic          vreg_ready,
    input  logic          clk_ready,
    output logic [VW-1:0] v_code,
    output logic [FW-1:0] f_code,
    output logic [IW-1:0] opp_idx,
    output logic          busy,
    output logic          waiting,
    output logic          wait_rdy
);

    localparam int SLOTS = 2 ** IW;

    logic [VW-1:0] vtab [SLOTS];
    logic [FW-1:0] ftab [SLOTS];

    for (genvar i = 0; i < SLOTS; i++) begin : g_tab
        localparam int K = (i < NUM_OPP) ? i : NUM_OPP - 1;
        assign vtab[i] = VW'(V_BASE + V_STEP * K);
        assign ftab[i] = FW'(F_BASE + F_STEP * K);
    end

    seq_state_e    state, nxt;
    logic [IW-1:0] seq_tgt;
    logic          start;
    logic          go_down;

    assign start   = (tgt_idx != opp_idx) && !hold;
    assign go_down = tgt_idx < opp_idx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SQ_VUP_SET;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            SQ_IDLE:     if (start) nxt = go_down ? SQ_FDN_SET : SQ_VUP_SET;
            SQ_FDN_SET:  nxt = SQ_FDN_WAIT;
            SQ_FDN_WAIT: if (clk_ready) nxt = SQ_VDN_SET;
            SQ_VDN_SET:  nxt = SQ_VDN_WAIT;
            SQ_VDN_WAIT: if (vreg_ready) nxt = SQ_IDLE;
            SQ_VUP_SET:  nxt = SQ_VUP_WAIT;
            SQ_VUP_WAIT: if (vreg_ready) nxt = SQ_FUP_SET;
            SQ_FUP_SET:  nxt = SQ_FUP_WAIT;
            SQ_FUP_WAIT: if (clk_ready) nxt = SQ_IDLE;
            default:     nxt = SQ_IDLE;
        endcase
    end

    // outputs: codes, committed index, latched sequence target
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_code  <= vtab[0];
            f_code  <= ftab[0];
            opp_idx <= '0;
            seq_tgt <= '0;
        end else begin
            unique case (state)
                SQ_IDLE: begin
                    if (start) begin
                        seq_tgt <= tgt_idx;
                        if (go_down) f_code <= ftab[tgt_idx];
                        else         v_code <= vtab[tgt_idx];
                    end
                end
                SQ_FDN_WAIT: if (clk_ready)  v_code  <= vtab[seq_tgt];
                SQ_VDN_WAIT: if (vreg_ready) opp_idx <= seq_tgt;
                SQ_VUP_WAIT: if (vreg_ready) f_code  <= ftab[seq_tgt];
                SQ_FUP_WAIT: if (clk_ready)  opp_idx <= seq_tgt;
                default: ;
            endcase
        end
    end

    assign busy    = state != SQ_IDLE;
    assign waiting = (state == SQ_FDN_WAIT) || (state == SQ_VDN_WAIT) ||
                     (state == SQ_VUP_WAIT) || (state == SQ_FUP_WAIT);
    assign wait_rdy = ((state == SQ_FDN_WAIT) || (state == SQ_FUP_WAIT)) ? clk_ready : vreg_ready;

endmodule

// File: rtl/dvfs_hs_timeout.sv
module dvfs_hs_timeout #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             waiting,
    input  logic             ready,
    input  logic [TMO_W-1:0] limit,
    output logic             err
);

    logic [TMO_W-1:0] cnt;
    logic [TMO_W:0]   cnt_next;

    assign cnt_next = {1'b0, cnt} + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            err <= 1'b0;
        end else if (waiting && !ready) begin
            if (cnt_next >= {1'b0, limit}) err <= 1'b1;
            if (cnt_next[TMO_W] == 1'b0) cnt <= cnt_next[TMO_W-1:0];
        end else begin
            cnt <= '0;
        end
    end

endmodule

// File: rtl/dvfs_opp_ctrl.sv
module dvfs_opp_ctrl
    import dvfs_pkg::*;
#(
    parameter int NUM_OPP = 3,
    parameter int UTIL_W  = 8,
    parameter int IDLE_W  = 16,
    parameter int TMO_W   = 16,
    parameter int LOW_RUN = 3,
    parameter int VW      = 6,
    parameter int FW      = 7,
    parameter int V_BASE  = 20,
    parameter int V_STEP  = 8,
    parameter int F_BASE  = 16,
    parameter int F_STEP  = 24,
    localparam int IW     = $clog2(NUM_OPP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              util_valid,
    input  logic [UTIL_W-1:0] util_sample,
    input  logic [UTIL_W-1:0] cfg_hi_thr,
    input  logic [UTIL_W-1:0] cfg_lo_thr,
    input  logic [1:0]        policy,
    input  logic              thermal_alarm,
    input  logic              wake_evt,
    input  logic              idle_valid,
    input  logic [IDLE_W-1:0] idle_pred,
    input  logic [IDLE_W-1:0] cfg_breakeven,
    input  logic [TMO_W-1:0]  cfg_tmo_limit,
    input  logic              vreg_ready,
    input  logic              clk_ready,
    output logic [VW-1:0]     v_code,
    output logic [FW-1:0]     f_code,
    output logic              gate_en,
    output logic              busy,
    output logic [IW-1:0]     opp_idx,
    output logic              hs_error
);

    logic [IW-1:0] tgt_idx;
    logic          gate_q;
    logic          waiting;
    logic          wait_rdy;
    logic          hold;

    dvfs_governor #(
        .NUM_OPP(NUM_OPP), .UTIL_W(UTIL_W), .IDLE_W(IDLE_W),
        .LOW_RUN(LOW_RUN), .IW(IW)
    ) u_gov (
        .clk(clk), .rst_n(rst_n),
        .util_valid(util_valid), .util_sample(util_sample),
        .cfg_hi_thr(cfg_hi_thr), .cfg_lo_thr(cfg_lo_thr),
        .policy(policy_e'(policy)), .thermal_alarm(thermal_alarm),
        .wake_evt(wake_evt), .idle_valid(idle_valid), .idle_pred(idle_pred),
        .cfg_breakeven(cfg_breakeven), .cur_idx(opp_idx),
        .tgt_idx(tgt_idx), .gate_q(gate_q)
    );

    // gating freezes the point unless the thermal override is active
    assign hold = gate_q && !thermal_alarm;

    dvfs_sequencer #(
        .NUM_OPP(NUM_OPP), .IW(IW), .VW(VW), .FW(FW),
        .V_BASE(V_BASE), .V_STEP(V_STEP), .F_BASE(F_BASE), .F_STEP(F_STEP)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .tgt_idx(tgt_idx), .hold(hold),
        .vreg_ready(vreg_ready), .clk_ready(clk_ready),
        .v_code(v_code), .f_code(f_code), .opp_idx(opp_idx), .busy(busy),
        .waiting(waiting), .wait_rdy(wait_rdy)
    );

    dvfs_hs_timeout #(.TMO_W(TMO_W)) u_tmo (
        .clk(clk), .rst_n(rst_n), .waiting(waiting), .ready(wait_rdy),
        .limit(cfg_tmo_limit), .err(hs_error)
    );

    assign gate_en = gate_q && !busy;

endmodule

// File: rtl/dvfs_opp_ctrl_chk.sv
module dvfs_opp_ctrl_chk #(
    parameter int NUM_OPP = 3,
    parameter int VW      = 6,
    parameter int FW      = 7,
    parameter int V_BASE  = 20,
    parameter int V_STEP  = 8,
    parameter int F_BASE  = 16,
    parameter int F_STEP  = 24,
    parameter int IW      = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [VW-1:0] v_code,
    input logic [FW-1:0] f_code,
    input logic          gate_en,
    input logic          busy,
    input logic [IW-1:0] opp_idx,
    input logic          hs_error
);

    function automatic int f_to_idx(logic [FW-1:0] f);
        int r = 0;
        for (int i = 0; i < NUM_OPP; i++)
            if (int'(f) == F_BASE + F_STEP * i) r = i;
        return r;
    endfunction

    // R1: codes at rest match the committed index
    a_r1_rest_codes: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (int'(v_code) == V_BASE + V_STEP * int'(opp_idx)) &&
                  (int'(f_code) == F_BASE + F_STEP * int'(opp_idx)));

    // R1: index stays in the table
    a_r1_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(opp_idx) < NUM_OPP);

    // R6: never both codes on one edge
    a_r6_single_code: assert property (@(posedge clk) disable iff (!rst_n)
        (f_code != $past(f_code)) |-> (v_code == $past(v_code)));

    // R6: frequency only rises once voltage already supports it
    a_r6_volt_before_freq: assert property (@(posedge clk) disable iff (!rst_n)
        (f_code > $past(f_code)) |-> (int'(v_code) >= V_BASE + V_STEP * f_to_idx(f_code)));

    // R7: any code movement happens inside a busy sequence
    a_r7_busy_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        ((v_code != $past(v_code)) || (f_code != $past(f_code))) |-> busy);

    // R10: gated core sees frozen codes
    a_r10_gate_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        gate_en |-> ($stable(v_code) && $stable(f_code)));

    // R12: error is sticky
    a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hs_error) |-> hs_error);

endmodule

bind dvfs_opp_ctrl dvfs_opp_ctrl_chk #(
    .NUM_OPP(NUM_OPP), .VW(VW), .FW(FW), .V_BASE(V_BASE), .V_STEP(V_STEP),
    .F_BASE(F_BASE), .F_STEP(F_STEP), .IW(IW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .v_code(v_code), .f_code(f_code),
    .gate_en(gate_en), .busy(busy), .opp_idx(opp_idx), .hs_error(hs_error)
);

// File: tb/dvfs_opp_ctrl_bench.sv
module dvfs_opp_ctrl_bench;

    localparam int BV = 20, SV = 8, BF = 16, SF = 24, DLY = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        util_valid = 1'b0;
    logic [7:0]  util_sample = '0;
    logic [7:0]  cfg_hi_thr = 8'd180;
    logic [7:0]  cfg_lo_thr = 8'd50;
    logic [1:0]  policy = 2'd0;
    logic        thermal_alarm = 1'b0;
    logic        wake_evt = 1'b0;
    logic        idle_valid = 1'b0;
    logic [15:0] idle_pred = '0;
    logic [15:0] cfg_breakeven = 16'd100;
    logic [15:0] cfg_tmo_limit = 16'd30;
    logic        vreg_ready, clk_ready;
    logic [5:0]  v_code;
    logic [6:0]  f_code;
    logic        gate_en, busy, hs_error;
    logic [1:0]  opp_idx;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    bit v_stuck = 0;
    int exp_q[$];

    always #4 clk = ~clk;

    dvfs_opp_ctrl u_dvfs_opp_ctrl (
        .clk(clk), .rst_n(rst_n), .util_valid(util_valid), .util_sample(util_sample),
        .cfg_hi_thr(cfg_hi_thr), .cfg_lo_thr(cfg_lo_thr), .policy(policy),
        .thermal_alarm(thermal_alarm), .wake_evt(wake_evt), .idle_valid(idle_valid),
        .idle_pred(idle_pred), .cfg_breakeven(cfg_breakeven), .cfg_tmo_limit(cfg_tmo_limit),
        .vreg_ready(vreg_ready), .clk_ready(clk_ready), .v_code(v_code), .f_code(f_code),
        .gate_en(gate_en), .busy(busy), .opp_idx(opp_idx), .hs_error(hs_error)
    );

    // regulator and synthesizer models: ready drops after a code change, returns after DLY
    logic [5:0] v_prev; logic [6:0] f_prev; int v_cnt, f_cnt;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vreg_ready <= 0; clk_ready <= 0; v_cnt <= DLY; f_cnt <= DLY;
            v_prev <= 6'(BV); f_prev <= 7'(BF);
        end else begin
            v_prev <= v_code; f_prev <= f_code;
            if (v_code != v_prev) begin vreg_ready <= 0; v_cnt <= DLY; end
            else if (v_cnt != 0) v_cnt <= v_cnt - 1;
            else vreg_ready <= !v_stuck;
            if (f_code != f_prev) begin clk_ready <= 0; f_cnt <= DLY; end
            else if (f_cnt != 0) f_cnt <= f_cnt - 1;
            else clk_ready <= 1'b1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_pt(input int idx);
        exp_q.push_back(idx);
    endtask

    // scoreboard monitor: each completed sequence is compared with the queue
    bit busy_d = 0;
    int mv_prev = BV, mf_prev = BF;
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy_d && !busy) begin
                if (exp_q.size() == 0) begin
                    check("R7 unexpected completion", int'(opp_idx), -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check("R7 point", int'(opp_idx), e);
                    check("R1 vcode", int'(v_code), BV + SV * e);
                    check("R1 fcode", int'(f_code), BF + SF * e);
                end
            end
            // R6 ordering seen at the ports
            if (int'(f_code) > mf_prev)
                check("R6 volt before freq rise", int'(v_code), BV + SV * ((int'(f_code) - BF) / SF));
            if (int'(v_code) < mv_prev)
                check("R6 freq before volt fall", int'(f_code), BF + SF * ((int'(v_code) - BV) / SV));
            busy_d  <= busy;
            mv_prev = int'(v_code);
            mf_prev = int'(f_code);
        end
    end

    task automatic util(input int s);
        @(negedge clk); util_valid = 1; util_sample = 8'(s);
        @(negedge clk); util_valid = 0;
    endtask

    task automatic quiet();
        int run = 0;
        for (int k = 0; k < 400 && run < 8; k++) begin
            @(negedge clk);
            if (busy) run = 0; else run++;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        expect_pt(0);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R2 reset state
        check("R2 busy", int'(busy), 1);
        check("R2 idx", int'(opp_idx), 0);
        check("R2 vcode", int'(v_code), BV);
        check("R2 fcode", int'(f_code), BF);
        check("R2 gate", int'(gate_en), 0);
        check("R2 err", int'(hs_error), 0);
        quiet();

        // R3 performance then powersave
        expect_pt(2); policy = 2'd2; quiet();
        expect_pt(0); policy = 2'd1; quiet();
        policy = 2'd0;

        // R4 step up on high samples
        expect_pt(1); util(200); quiet();
        expect_pt(2); util(200); quiet();
        util(200); quiet();
        check("R4 saturate", int'(opp_idx), 2);

        // R5 hysteresis
        util(10); util(10); util(100); util(10); util(10); quiet();
        check("R5 no drop before run", int'(opp_idx), 2);
        check("R5 idle", int'(busy), 0);
        expect_pt(1); util(10); quiet();

        // R8 target change mid-sequence
        expect_pt(0); expect_pt(2);
        policy = 2'd1;
        for (int k = 0; k < 20 && !busy; k++) @(negedge clk);
        policy = 2'd2;
        quiet();
        check("R8 ends at new target", int'(opp_idx), 2);
        expect_pt(1); policy = 2'd0; quiet();

        // R9 thermal override
        expect_pt(2); util(200); quiet();
        expect_pt(1); thermal_alarm = 1; quiet();
        util(200); quiet();
        check("R9 capped", int'(opp_idx), 1);
        expect_pt(2); thermal_alarm = 0; quiet();
        policy = 2'd2;
        expect_pt(1); thermal_alarm = 1; quiet();
        expect_pt(2); thermal_alarm = 0; quiet();
        policy = 2'd0;

        // R10 clock gating on short idle
        @(negedge clk); idle_valid = 1; idle_pred = 16'd5;
        @(negedge clk); idle_valid = 0;
        @(negedge clk);
        check("R10 gate on", int'(gate_en), 1);
        util(10); util(10); util(10); quiet();
        check("R10 point held", int'(opp_idx), 2);
        check("R10 gate held", int'(gate_en), 1);
        expect_pt(0);
        @(negedge clk); idle_valid = 1; idle_pred = 16'd500;
        @(negedge clk); idle_valid = 0;
        quiet();
        check("R10 gate off", int'(gate_en), 0);

        // R11 wake ramps to top
        expect_pt(2);
        @(negedge clk); wake_evt = 1;
        @(negedge clk); wake_evt = 0;
        quiet();
        check("R12 no error yet", int'(hs_error), 0);

        // R12 stuck regulator
        v_stuck = 1;
        expect_pt(0); policy = 2'd1;
        repeat (60) @(negedge clk);
        check("R12 error set", int'(hs_error), 1);
        check("R7 still busy", int'(busy), 1);
        check("R7 point unchanged", int'(opp_idx), 2);
        v_stuck = 0;
        quiet();
        check("R12 sticky", int'(hs_error), 1);

        // R3 reserved encoding follows load (level is at top after wake)
        expect_pt(2); policy = 2'd3; quiet();
        check("R3 reserved", int'(opp_idx), 2);

        check("R7 queue drained", exp_q.size(), 0);
        finish_run();
    end

endmodule